// File: doc/BRIEF.md
# System Power Mode Controller

This block steps a processor system through four power modes: a full-speed mode on the PLL, a slow mode on the crystal oscillator, a doze mode with the CPU stopped, and a sleep mode with every system clock stopped. Software asks for a mode by writing a three-bit mode code, together with a two-bit oscillator divider code, through a one-cycle write strobe. The block then drives the PLL enable and a one-hot clock source select. It also produces clock enables for the CPU, the system bus and the peripherals, and reports its mode on a status output.

A change of clock source always passes through one cycle in which no source is selected. Entering full-speed mode first switches the PLL on and waits for its lock input before the source changes. A wake from sleep, caused by either an IRQ or an FIQ, always lands in slow mode. A wake from doze returns to the mode that was active before doze. The PLL, the oscillators and any spread-spectrum modulation lie outside the block; they appear only as the enable, lock and select signals.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the status reads SLOW (3'b010), the source select is the oscillator (3'b010), the divider code is 0 (/1), the PLL enable is low, and all three clock enables are low.
- R2: Mode codes are SLEEP 3'b000, DOZE 3'b001, SLOW 3'b010 and NORMAL 3'b100. A write carrying any other code is ignored as a whole: mode and divider code are unchanged.
- R3: Moving between SLOW and DOZE, which share the oscillator source, takes effect in the cycle after the write, with no gap in the source select.
- R4: The source select is one-hot or zero, with PLL = 3'b001, oscillator = 3'b010 and low-speed = 3'b100. Every change of source passes through exactly one cycle with the select at zero, and the status reads 3'b111 during that cycle.
- R5: A move to NORMAL from an oscillator mode raises the PLL enable and keeps the old source. The status reads 3'b111 until the PLL lock input is seen high. The gap cycle and the switch to the PLL follow.
- R6: In NORMAL the CPU enable is high every cycle, the bus enable every second cycle and the peripheral enable every fourth cycle, all three together on the first enabled cycle.
- R7: In SLEEP all three clock enables are low, the PLL is off, and the source select is the low-speed clock, which also clocks the controller.
- R8: In SLEEP, an IRQ or an FIQ starts a wake: one gap cycle, then SLOW on the oscillator.
- R9: In DOZE the CPU enable is low while bus and peripheral enables stay high. An IRQ or FIQ returns to the mode that was active when DOZE was requested. A return to NORMAL goes through the lock wait of R5.
- R10: Writes are accepted only when the status reads SLOW or NORMAL. IRQ and FIQ have no effect in SLOW or NORMAL.
- R11: An accepted write stores its divider code (0 = /1, 1 = /2, 2 = /4, 3 = /8) on the divider output, even when the mode code equals the current mode.
- R12: The PLL enable is low whenever the status reads SLEEP, DOZE or SLOW.
- R13: Clock enables are registered: they follow the status with one cycle of delay, and they are all low during the lock wait and the gap cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe for a mode request |
| wr_mode | input | 3 | Requested mode code |
| wr_div | input | 2 | Oscillator divider code |
| irq | input | 1 | Normal interrupt request (wake) |
| fiq | input | 1 | Fast interrupt request (wake) |
| pll_lock | input | 1 | PLL lock indication |
| pll_en | output | 1 | PLL enable |
| sys_src | output | 3 | One-hot clock source select: bit0 PLL, bit1 oscillator, bit2 low-speed |
| osc_div | output | 2 | Oscillator divider code in use |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | System bus clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| mode_status | output | 3 | Current mode code, 3'b111 while in transition |

## Verification
The hardest situation to reach is the path from doze back to full speed. It needs a NORMAL request, a lock wait, a DOZE request that takes the PLL down through a gap, and then an interrupt that must bring the PLL back up and wait for lock again. The stimulus builds this path on purpose. The bench's PLL model raises lock a fixed number of cycles after the enable rises and drops it as soon as the enable falls, so every return to NORMAL needs a fresh lock wait. A long stretch of random writes, invalid codes and interrupts follows, with a behavioural model compared on every clock.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int MODE_W = 3;
  localparam int SRC_W  = 3;

  localparam logic [MODE_W-1:0] MD_SLEEP  = 3'b000;
  localparam logic [MODE_W-1:0] MD_DOZE   = 3'b001;
  localparam logic [MODE_W-1:0] MD_SLOW   = 3'b010;
  localparam logic [MODE_W-1:0] MD_NORMAL = 3'b100;
  localparam logic [MODE_W-1:0] MD_TRANS  = 3'b111;

  localparam logic [SRC_W-1:0] SRC_NONE = 3'b000;
  localparam logic [SRC_W-1:0] SRC_PLL  = 3'b001;
  localparam logic [SRC_W-1:0] SRC_OSC  = 3'b010;
  localparam logic [SRC_W-1:0] SRC_LP   = 3'b100;

  typedef enum logic [1:0] {
    SQ_RUN  = 2'd0,
    SQ_LOCK = 2'd1,
    SQ_GAP  = 2'd2
  } seq_t;

  function automatic logic code_ok(input logic [MODE_W-1:0] m);
    return (m == MD_SLEEP) || (m == MD_DOZE) || (m == MD_SLOW) || (m == MD_NORMAL);
  endfunction

  function automatic logic [SRC_W-1:0] src_of(input logic [MODE_W-1:0] m);
    logic [SRC_W-1:0] s;
    case (m)
      MD_NORMAL: s = SRC_PLL;
      MD_SLEEP:  s = SRC_LP;
      default:   s = SRC_OSC;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pmc_req_decode.sv
module pmc_req_decode
  import pmc_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic [DIV_W-1:0]  wr_div,
  input  logic              open_i,
  output logic              accept_o,
  output logic [DIV_W-1:0]  div_o
);

  logic [DIV_W-1:0] div_q;

  assign accept_o = wr_en && open_i && code_ok(wr_mode);
  assign div_o    = div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (accept_o) begin
      div_q <= wr_div;
    end
  end

  // R2: a write with an unknown code leaves the divider alone
  p_bad_code_keeps_div_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !code_ok(wr_mode)) |=> $stable(div_q));

  // R10: a write while closed leaves the divider alone
  p_closed_keeps_div_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !open_i) |=> $stable(div_q));

endmodule

// File: rtl/pmc_sequencer.sv
module pmc_sequencer
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic [MODE_W-1:0] wr_mode_i,
  input  logic              irq_i,
  input  logic              fiq_i,
  input  logic              pll_lock_i,
  output logic              open_o,
  output logic              run_o,
  output logic [MODE_W-1:0] cur_o,
  output logic [MODE_W-1:0] status_o,
  output logic [SRC_W-1:0]  src_o,
  output logic              pll_en_o
);

  seq_t              state_q, state_n;
  logic [MODE_W-1:0] cur_q, cur_n;
  logic [MODE_W-1:0] prev_q, prev_n;
  logic [MODE_W-1:0] tgt_q, tgt_n;
  logic [MODE_W-1:0] status_q, status_n;
  logic [SRC_W-1:0]  src_q, src_n;
  logic              pll_q, pll_n;

  logic              run;
  logic              asleep;
  logic              wake;
  logic              go;
  logic [MODE_W-1:0] dest;

  assign run    = (state_q == SQ_RUN);
  assign asleep = (cur_q == MD_SLEEP) || (cur_q == MD_DOZE);
  assign open_o = run && ((cur_q == MD_SLOW) || (cur_q == MD_NORMAL));
  assign wake   = run && asleep && (irq_i || fiq_i);
  assign dest   = wake ? ((cur_q == MD_SLEEP) ? MD_SLOW : prev_q) : wr_mode_i;
  assign go     = wake || (accept_i && (wr_mode_i != cur_q));

  always_comb begin
    state_n = state_q;
    cur_n   = cur_q;
    prev_n  = prev_q;
    tgt_n   = tgt_q;
    src_n   = src_q;
    pll_n   = pll_q;
    case (state_q)
      SQ_RUN: begin
        if (go) begin
          if (!wake && (dest == MD_DOZE)) begin
            prev_n = cur_q;
          end
          if (src_of(dest) == src_of(cur_q)) begin
            cur_n = dest;
          end else if (dest == MD_NORMAL) begin
            state_n = SQ_LOCK;
            pll_n   = 1'b1;
            tgt_n   = dest;
          end else begin
            state_n = SQ_GAP;
            src_n   = SRC_NONE;
            pll_n   = 1'b0;
            tgt_n   = dest;
          end
        end
      end
      SQ_LOCK: begin
        if (pll_lock_i) begin
          state_n = SQ_GAP;
          src_n   = SRC_NONE;
        end
      end
      SQ_GAP: begin
        state_n = SQ_RUN;
        src_n   = src_of(tgt_q);
        cur_n   = tgt_q;
      end
      default: state_n = SQ_RUN;
    endcase
    status_n = (state_n == SQ_RUN) ? cur_n : MD_TRANS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_RUN;
      cur_q    <= MD_SLOW;
      prev_q   <= MD_SLOW;
      tgt_q    <= MD_SLOW;
      status_q <= MD_SLOW;
      src_q    <= SRC_OSC;
      pll_q    <= 1'b0;
    end else begin
      state_q  <= state_n;
      cur_q    <= cur_n;
      prev_q   <= prev_n;
      tgt_q    <= tgt_n;
      status_q <= status_n;
      src_q    <= src_n;
      pll_q    <= pll_n;
    end
  end

  assign run_o    = run;
  assign cur_o    = cur_q;
  assign status_o = status_q;
  assign src_o    = src_q;
  assign pll_en_o = pll_q;

  // R4: never two sources at once
  p_src_onehot0_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_q));

  // R4: a nonzero source is never replaced by another without a zero cycle
  p_no_direct_swap_r4: assert property (@(posedge clk) disable iff (rst)
    ((src_q != SRC_NONE) && ($past(src_q) != SRC_NONE)) |-> (src_q == $past(src_q)));

  // R5: the PLL is only selected while it is enabled
  p_pll_sel_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
    src_q[0] |-> pll_q);

  // R5: the lock wait holds the old source until lock is seen
  p_lock_wait_holds_r5: assert property (@(posedge clk) disable iff (rst)
    ((state_q == SQ_LOCK) && !pll_lock_i) |=> ((state_q == SQ_LOCK) && $stable(src_q)));

  // R8: an interrupt in sleep starts a gap towards slow mode
  p_sleep_wake_r8: assert property (@(posedge clk) disable iff (rst)
    (run && (cur_q == MD_SLEEP) && (irq_i || fiq_i)) |=> ((state_q == SQ_GAP) && (tgt_q == MD_SLOW)));

  // R12: the PLL is off in every steady mode but full speed
  p_pll_off_r12: assert property (@(posedge clk) disable iff (rst)
    (run && (cur_q != MD_NORMAL)) |-> !pll_q);

endmodule

// File: rtl/pmc_clk_enables.sv
module pmc_clk_enables
  import pmc_pkg::*;
#(
  parameter int BUS_SHIFT = 1,
  parameter int PER_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              cpu_en_o,
  output logic              bus_en_o,
  output logic              per_en_o
);

  localparam int CW = (PER_SHIFT < 1) ? 1 : PER_SHIFT;

  logic [CW-1:0] ph_q;
  logic          bus_tick;
  logic          per_tick;
  logic          fast;
  logic          cpu_q, bus_q, per_q;

  assign fast = run_i && (mode_i == MD_NORMAL);

  generate
    if (BUS_SHIFT == 0) begin : g_bus_full
      assign bus_tick = 1'b1;
    end else begin : g_bus_div
      assign bus_tick = (ph_q[BUS_SHIFT-1:0] == '0);
    end
    if (PER_SHIFT == 0) begin : g_per_full
      assign per_tick = 1'b1;
    end else begin : g_per_div
      assign per_tick = (ph_q[PER_SHIFT-1:0] == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= '0;
      cpu_q <= 1'b0;
      bus_q <= 1'b0;
      per_q <= 1'b0;
    end else begin
      ph_q  <= fast ? ph_q + 1'b1 : '0;
      cpu_q <= run_i && ((mode_i == MD_NORMAL) || (mode_i == MD_SLOW));
      bus_q <= run_i && ((fast && bus_tick) || (mode_i == MD_SLOW) || (mode_i == MD_DOZE));
      per_q <= run_i && ((fast && per_tick) || (mode_i == MD_SLOW) || (mode_i == MD_DOZE));
    end
  end

  assign cpu_en_o = cpu_q;
  assign bus_en_o = bus_q;
  assign per_en_o = per_q;

  // R7: sleep stops every clock on the next cycle
  p_sleep_gates_r7: assert property (@(posedge clk) disable iff (rst)
    (run_i && (mode_i == MD_SLEEP)) |=> (!cpu_q && !bus_q && !per_q));

  // R9: doze stops the CPU only
  p_doze_cpu_off_r9: assert property (@(posedge clk) disable iff (rst)
    (run_i && (mode_i == MD_DOZE)) |=> (!cpu_q && bus_q && per_q));

  // R13: transition cycles stop every clock on the next cycle
  p_trans_gates_r13: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (!cpu_q && !bus_q && !per_q));

  generate
    if (BUS_SHIFT > 0) begin : g_ratio_chk
      // R6: in full speed a bus enable is never followed by another at once
      p_bus_half_r6: assert property (@(posedge clk) disable iff (rst)
        (fast && cpu_q && bus_q) |=> !bus_q);
    end
  endgenerate

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int DIV_W     = 2,
  parameter int BUS_SHIFT = 1,
  parameter int PER_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_mode,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             irq,
  input  logic             fiq,
  input  logic             pll_lock,
  output logic             pll_en,
  output logic [2:0]       sys_src,
  output logic [DIV_W-1:0] osc_div,
  output logic             cpu_clk_en,
  output logic             bus_clk_en,
  output logic             per_clk_en,
  output logic [2:0]       mode_status
);

  logic              accept;
  logic              open_w;
  logic              run_w;
  logic [MODE_W-1:0] cur_w;

  pmc_req_decode #(.DIV_W(DIV_W)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_mode  (wr_mode),
    .wr_div   (wr_div),
    .open_i   (open_w),
    .accept_o (accept),
    .div_o    (osc_div)
  );

  pmc_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .accept_i   (accept),
    .wr_mode_i  (wr_mode),
    .irq_i      (irq),
    .fiq_i      (fiq),
    .pll_lock_i (pll_lock),
    .open_o     (open_w),
    .run_o      (run_w),
    .cur_o      (cur_w),
    .status_o   (mode_status),
    .src_o      (sys_src),
    .pll_en_o   (pll_en)
  );

  pmc_clk_enables #(.BUS_SHIFT(BUS_SHIFT), .PER_SHIFT(PER_SHIFT)) u_en (
    .clk      (clk),
    .rst      (rst),
    .run_i    (run_w),
    .mode_i   (cur_w),
    .cpu_en_o (cpu_clk_en),
    .bus_en_o (bus_clk_en),
    .per_en_o (per_clk_en)
  );

endmodule

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_mode = 3'b010;
  logic [1:0] wr_div = 2'd0;
  logic       irq = 1'b0;
  logic       fiq = 1'b0;
  logic       pll_lock = 1'b0;
  logic       pll_en;
  logic [2:0] sys_src;
  logic [1:0] osc_div;
  logic       cpu_clk_en, bus_clk_en, per_clk_en;
  logic [2:0] mode_status;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  int    lock_cnt = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mode(wr_mode), .wr_div(wr_div),
    .irq(irq), .fiq(fiq), .pll_lock(pll_lock), .pll_en(pll_en), .sys_src(sys_src),
    .osc_div(osc_div), .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en),
    .per_clk_en(per_clk_en), .mode_status(mode_status)
  );

  // PLL stand-in: lock four cycles after enable, lost at once when disabled
  always @(negedge clk) begin
    if (!pll_en) lock_cnt = 0;
    else if (lock_cnt < 100) lock_cnt = lock_cnt + 1;
    pll_lock <= (lock_cnt >= 4);
  end

  // ---------------- reference model ----------------
  int m_st, m_cur, m_prev, m_tgt, m_src, m_pll, m_div, m_ph;
  int m_cpu, m_bus, m_per;

  function automatic int src_for(int m);
    if (m == 4) return 1;
    if (m == 0) return 4;
    return 2;
  endfunction

  function automatic bit known(int m);
    return (m == 0) || (m == 1) || (m == 2) || (m == 4);
  endfunction

  always @(posedge clk) begin
    int exp_status;
    bit mism;
    if (rst) begin
      m_st = 0; m_cur = 2; m_prev = 2; m_tgt = 2; m_src = 2; m_pll = 0; m_div = 0;
      m_ph = 0; m_cpu = 0; m_bus = 0; m_per = 0;
    end else begin
      bit running, wk, acc;
      int d;
      running = (m_st == 0);
      m_cpu = (running && (m_cur == 4 || m_cur == 2)) ? 1 : 0;
      m_bus = (running && ((m_cur == 4 && (m_ph % 2) == 0) || m_cur == 2 || m_cur == 1)) ? 1 : 0;
      m_per = (running && ((m_cur == 4 && m_ph == 0) || m_cur == 2 || m_cur == 1)) ? 1 : 0;
      m_ph  = (running && m_cur == 4) ? (m_ph + 1) % 4 : 0;
      wk  = running && (m_cur == 0 || m_cur == 1) && (irq || fiq);
      acc = wr_en && known(int'(wr_mode)) && running && (m_cur == 2 || m_cur == 4);
      if (acc) m_div = int'(wr_div);
      if (m_st == 0) begin
        if (wk || (acc && int'(wr_mode) != m_cur)) begin
          d = wk ? ((m_cur == 0) ? 2 : m_prev) : int'(wr_mode);
          if (!wk && d == 1) m_prev = m_cur;
          if (src_for(d) == src_for(m_cur)) m_cur = d;
          else if (d == 4) begin m_st = 1; m_pll = 1; m_tgt = d; end
          else begin m_st = 2; m_src = 0; m_pll = 0; m_tgt = d; end
        end
      end else if (m_st == 1) begin
        if (pll_lock) begin m_st = 2; m_src = 0; end
      end else begin
        m_st = 0; m_src = src_for(m_tgt); m_cur = m_tgt;
      end
    end
    #1;
    if (!rst && !done) begin
      exp_status = (m_st == 0) ? m_cur : 7;
      mism = (int'(mode_status) != exp_status) || (int'(sys_src) != m_src) ||
             (int'(pll_en) != m_pll) || (int'(osc_div) != m_div) ||
             (int'(cpu_clk_en) != m_cpu) || (int'(bus_clk_en) != m_bus) ||
             (int'(per_clk_en) != m_per);
      checks++;
      if (mism) begin
        failures++;
        $display("FAIL %s model: actual st=%0d src=%0d pll=%0d div=%0d en=%0d%0d%0d expected st=%0d src=%0d pll=%0d div=%0d en=%0d%0d%0d",
                 cur_req, mode_status, sys_src, pll_en, osc_div, cpu_clk_en, bus_clk_en, per_clk_en,
                 exp_status, m_src, m_pll, m_div, m_cpu, m_bus, m_per);
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected below 50000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int m, input int dv);
    wr_en = 1'b1; wr_mode = m[2:0]; wr_div = dv[1:0];
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse_irq(input bit fast);
    if (fast) fiq = 1'b1; else irq = 1'b1;
    tick();
    fiq = 1'b0; irq = 1'b0;
  endtask

  task automatic wait_status(input string tag, input int code, output bit saw_gap);
    int n;
    saw_gap = 0;
    n = 0;
    while (int'(mode_status) != code && n < 60) begin
      if (sys_src == 3'b000) saw_gap = 1;
      tick();
      n++;
    end
    chk(tag, int'(mode_status), code);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    bit gap;
    int nc, nb, np;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    cur_req = "R1";
    chk("R1 status", int'(mode_status), 2);
    chk("R1 source", int'(sys_src), 2);
    chk("R1 pll", int'(pll_en), 0);
    chk("R1 divider", int'(osc_div), 0);

    cur_req = "R11";
    wr(2, 3);
    chk("R11 divider stored", int'(osc_div), 3);

    cur_req = "R2";
    wr(3, 1);
    chk("R2 bad code status", int'(mode_status), 2);
    chk("R2 bad code divider", int'(osc_div), 3);
    wr(7, 0);
    chk("R2 code 7 divider", int'(osc_div), 3);

    cur_req = "R3";
    wr(1, 3);
    chk("R3 doze next cycle", int'(mode_status), 1);
    chk("R3 source kept", int'(sys_src), 2);
    tick();
    cur_req = "R9";
    chk("R9 doze cpu off", int'(cpu_clk_en), 0);
    chk("R9 doze bus on", int'(bus_clk_en), 1);
    cur_req = "R10";
    wr(4, 0);
    chk("R10 write in doze ignored", int'(mode_status), 1);
    chk("R10 divider kept in doze", int'(osc_div), 3);
    cur_req = "R9";
    pulse_irq(0);
    chk("R9 irq returns to slow", int'(mode_status), 2);

    cur_req = "R5";
    wr(4, 1);
    chk("R5 transitional", int'(mode_status), 7);
    chk("R5 pll enabled", int'(pll_en), 1);
    chk("R5 old source held", int'(sys_src), 2);
    wait_status("R5 reach normal", 4, gap);
    chk("R4 gap before pll", int'(gap), 1);
    chk("R4 pll selected", int'(sys_src), 1);

    cur_req = "R6";
    tick();
    nc = 0; nb = 0; np = 0;
    for (int i = 0; i < 8; i++) begin
      nc += int'(cpu_clk_en); nb += int'(bus_clk_en); np += int'(per_clk_en);
      tick();
    end
    chk("R6 cpu count", nc, 8);
    chk("R6 bus count", nb, 4);
    chk("R6 per count", np, 2);

    cur_req = "R10";
    pulse_irq(1);
    chk("R10 fiq in normal ignored", int'(mode_status), 4);

    cur_req = "R12";
    wr(1, 2);
    wait_status("R12 reach doze", 1, gap);
    chk("R12 pll off in doze", int'(pll_en), 0);
    chk("R4 doze on oscillator", int'(sys_src), 2);
    cur_req = "R9";
    pulse_irq(1);
    wait_status("R9 fiq back to normal", 4, gap);
    chk("R9 back on pll", int'(sys_src), 1);

    cur_req = "R7";
    wr(0, 0);
    wait_status("R7 reach sleep", 0, gap);
    tick();
    chk("R7 cpu off", int'(cpu_clk_en), 0);
    chk("R7 bus off", int'(bus_clk_en), 0);
    chk("R7 per off", int'(per_clk_en), 0);
    chk("R7 low-speed source", int'(sys_src), 4);
    chk("R12 pll off in sleep", int'(pll_en), 0);
    cur_req = "R10";
    wr(2, 1);
    repeat (4) tick();
    chk("R10 write in sleep ignored", int'(mode_status), 0);
    cur_req = "R8";
    pulse_irq(1);
    chk("R8 gap after fiq", int'(mode_status), 7);
    chk("R8 gap source zero", int'(sys_src), 0);
    tick();
    chk("R8 lands in slow", int'(mode_status), 2);
    chk("R8 oscillator source", int'(sys_src), 2);
    tick();
    chk("R13 slow cpu enable", int'(cpu_clk_en), 1);
    wr(0, 2);
    tick();
    tick();
    pulse_irq(0);
    tick();
    chk("R8 irq wake to slow", int'(mode_status), 2);

    cur_req = "R13";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 16);
      wr_en = (r < 5);
      wr_mode = 3'($urandom % 8);
      wr_div = 2'($urandom % 4);
      irq = ($urandom % 13) == 0;
      fiq = ($urandom % 17) == 0;
      tick();
    end
    wr_en = 1'b0; irq = 1'b0; fiq = 1'b0;
    repeat (3) tick();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule